// File: doc/BRIEF.md
# SD Host Command and Status Register Block

This block is the register front end of an SD card host. Software writes an argument and then a command word on a simple word-wide register bus. A command word with its start bit set sends a one-cycle request, carrying the command index and argument, to a card-side agent. The block then waits for that agent's response strobe. When the response arrives, the block checks the returned length against what the command asked for. It stores a short or long response in four read-only response words, or it flags a failure. It then clears the start bit so that software polling the command register sees completion.

A status register gathers the command-timeout flag and the busy-completion flag. Each status bit stays set until software writes a 1 to it. A single registered interrupt line is raised while any of the three interrupt-class status bits is set. The configuration register, block size and block count registers are plain storage. The configuration register also gates the busy-completion flag.

Register offsets (byte addresses): command 0x00, argument 0x04, response words 0x10/0x14/0x18/0x1C, status 0x20, configuration 0x38, block size 0x3C, block count 0x50.

Top module: `sdh_cmd_regs`

## Requirements
- R1: After reset, the command, argument, response, status, configuration, block size and block count registers read 0. `irq` and `card_req_valid` are low.
- R2: A write to offset 0x00 with bit 15 set, while no command is pending, stores the word. On the next cycle it drives `card_req_valid` for exactly one cycle, with `card_req_index` equal to bits 5:0 and `card_req_arg` equal to the argument register. Bit 15 reads back as 1 until the response arrives.
- R3: In the cycle `card_rsp_valid` is seen while a command is pending, bit 15 of the command register clears. If command bit 10 (no response) is set, any length is accepted and the response words keep their values.
- R4: Byte k of `card_rsp_data` is bits 8k+7:8k. A 4-byte response loads response word 0 (offset 0x10) as {byte0, byte1, byte2, byte3}, with byte0 as the most significant byte. Words 1 to 3 become 0.
- R5: A 16-byte response loads word n (offset 0x10+4n) from bytes 12-4n to 15-4n, the lowest-numbered byte most significant. Word 0 thus holds bytes 12..15 and word 3 holds bytes 0..3.
- R6: When a response is expected, the command fails if the length is neither 4 nor 16, or is 4 while bit 9 (long response) is set. On failure, command bit 14 and status bit 6 are set and the response words are not changed.
- R7: A successful command with bit 11 (busy wait) set sets status bit 10, but only if configuration bit 10 is 1.
- R8: A write to offset 0x20 clears each status bit written as 1 and leaves the others unchanged.
- R9: `irq` is high one cycle after any of status bits 10, 9 or 8 is set, and low one cycle after all three are clear.
- R10: Reads of any other offset, 0x40 included, return 0. Writes to them change no register. A command-register write while a command is pending is ignored and sends no request.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read.
- R12: The argument (32 bits), configuration (11 bits), block size (32 bits) and block count (9 bits) registers read back what was written, truncated to their widths. Writes to the response words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| card_req_valid | output | 1 | One-cycle command request to the card agent |
| card_req_index | output | 6 | Command index of the request |
| card_req_arg | output | 32 | Command argument of the request |
| card_rsp_valid | input | 1 | Response strobe from the card agent |
| card_rsp_len | input | 5 | Response length in bytes |
| card_rsp_data | input | 128 | Response bytes, byte k at bits 8k+7:8k |
| irq | output | 1 | Registered interrupt line |

## Verification
The bench builds the block with its default 8-bit address width. That width reaches every mapped offset, the unused data window at 0x40 and an unmapped offset just above it. The bench acts as the card agent itself and delays its responses by a varying number of cycles. This lets it read the command register while a command is in flight and try a second launch during that window. It sweeps response lengths 0, 4, 8 and 16 against both the long-response and no-response command forms, and follows the interrupt edge cycle by cycle through a busy completion and its clearing write.

// File: rtl/sdh_pkg.sv
package sdh_pkg;
  localparam int WORD_W = 32;
  localparam int CMD_W  = 16;
  localparam int IDX_W  = 6;
  localparam int LEN_W  = 5;
  localparam int STAT_W = 11;
  localparam int CFG_W  = 11;
  localparam int BCNT_W = 9;
  localparam int RSP_WORDS = 4;
  localparam int RSP_BITS  = RSP_WORDS * WORD_W;

  localparam logic [7:0] OFF_CMD   = 8'h00;
  localparam logic [7:0] OFF_ARG   = 8'h04;
  localparam logic [7:0] OFF_RSP0  = 8'h10;
  localparam logic [7:0] OFF_STAT  = 8'h20;
  localparam logic [7:0] OFF_CFG   = 8'h38;
  localparam logic [7:0] OFF_BSIZE = 8'h3C;
  localparam logic [7:0] OFF_BCNT  = 8'h50;

  localparam int CB_START = 15;
  localparam int CB_FAIL  = 14;
  localparam int CB_BUSY  = 11;
  localparam int CB_NORSP = 10;
  localparam int CB_LONG  = 9;

  localparam int SB_BUSYIRQ = 10;
  localparam int SB_BLKIRQ  = 9;
  localparam int SB_DATIRQ  = 8;
  localparam int SB_CMDTO   = 6;

  localparam int CFG_BUSYEN = 10;

  localparam logic [STAT_W-1:0] IRQ_SRC_MASK =
    STAT_W'((1 << SB_BUSYIRQ) | (1 << SB_BLKIRQ) | (1 << SB_DATIRQ));

  function automatic logic len_is_bad(input logic [LEN_W-1:0] len,
                                      input logic want_long);
    return ((len != LEN_W'(4)) && (len != LEN_W'(16))) ||
           ((len == LEN_W'(4)) && want_long);
  endfunction
endpackage

// File: rtl/sdh_resp_pack.sv
module sdh_resp_pack #(
  parameter int NW = 4
) (
  input  logic [8*4*NW-1:0]     raw,
  input  logic                  long_fmt,
  output logic [NW-1:0][31:0]   words
);
  localparam int LAST = NW - 1;

  for (genvar g = 0; g < NW; g++) begin : g_word
    localparam int LB = (LAST - g) * 4;
    logic [31:0] long_w;
    logic [31:0] short_w;
    assign long_w = {raw[8*LB +: 8], raw[8*(LB+1) +: 8],
                     raw[8*(LB+2) +: 8], raw[8*(LB+3) +: 8]};
    if (g == 0) begin : g_first
      assign short_w = {raw[0 +: 8], raw[8 +: 8], raw[16 +: 8], raw[24 +: 8]};
    end else begin : g_rest
      assign short_w = '0;
    end
    assign words[g] = long_fmt ? long_w : short_w;
  end
endmodule

// File: rtl/sdh_issue.sv
module sdh_issue
  import sdh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [WORD_W-1:0] start_arg,
  input  logic              want_rsp,
  input  logic              want_long,
  input  logic              busy_wait,
  input  logic              busy_en,
  input  logic              rsp_valid,
  input  logic [LEN_W-1:0]  rsp_len,
  output logic              req_valid,
  output logic [IDX_W-1:0]  req_index,
  output logic [WORD_W-1:0] req_arg,
  output logic              pending,
  output logic              done,
  output logic              fail,
  output logic              take_rsp,
  output logic              busy_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      req_valid <= 1'b0;
      req_index <= '0;
      req_arg   <= '0;
    end else begin
      req_valid <= start;
      if (start) begin
        pending   <= 1'b1;
        req_index <= start_idx;
        req_arg   <= start_arg;
      end else if (done) begin
        pending <= 1'b0;
      end
    end
  end

  assign done      = rsp_valid && pending;
  assign fail      = done && want_rsp && len_is_bad(rsp_len, want_long);
  assign take_rsp  = done && want_rsp && !fail;
  assign busy_flag = done && !fail && busy_wait && busy_en;
endmodule

// File: rtl/sdh_status.sv
module sdh_status #(
  parameter int SW = 11,
  parameter logic [SW-1:0] IRQ_MASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] set_bits,
  input  logic [SW-1:0] clr_bits,
  output logic [SW-1:0] status,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~clr_bits) | set_bits;
      irq    <= |(status & IRQ_MASK);
    end
  end
endmodule

// File: rtl/sdh_cmd_regs.sv
module sdh_cmd_regs
  import sdh_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  output logic                card_req_valid,
  output logic [IDX_W-1:0]    card_req_index,
  output logic [WORD_W-1:0]   card_req_arg,
  input  logic                card_rsp_valid,
  input  logic [LEN_W-1:0]    card_rsp_len,
  input  logic [RSP_BITS-1:0] card_rsp_data,
  output logic                irq
);
  logic [CMD_W-1:0]  cmd_q;
  logic [WORD_W-1:0] arg_q;
  logic [RSP_WORDS-1:0][WORD_W-1:0] rsp_q;
  logic [CFG_W-1:0]  cfg_q;
  logic [WORD_W-1:0] bsize_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic [STAT_W-1:0] stat_q;

  logic hit_cmd, hit_arg, hit_stat, hit_cfg, hit_bsize, hit_bcnt;
  assign hit_cmd   = bus_addr == ADDR_W'(OFF_CMD);
  assign hit_arg   = bus_addr == ADDR_W'(OFF_ARG);
  assign hit_stat  = bus_addr == ADDR_W'(OFF_STAT);
  assign hit_cfg   = bus_addr == ADDR_W'(OFF_CFG);
  assign hit_bsize = bus_addr == ADDR_W'(OFF_BSIZE);
  assign hit_bcnt  = bus_addr == ADDR_W'(OFF_BCNT);

  logic pending, done, fail, take_rsp, busy_flag, start;
  assign start = bus_wr && hit_cmd && bus_wdata[CB_START] && !pending;

  sdh_issue u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_idx (bus_wdata[IDX_W-1:0]),
    .start_arg (arg_q),
    .want_rsp  (!cmd_q[CB_NORSP]),
    .want_long (cmd_q[CB_LONG]),
    .busy_wait (cmd_q[CB_BUSY]),
    .busy_en   (cfg_q[CFG_BUSYEN]),
    .rsp_valid (card_rsp_valid),
    .rsp_len   (card_rsp_len),
    .req_valid (card_req_valid),
    .req_index (card_req_index),
    .req_arg   (card_req_arg),
    .pending   (pending),
    .done      (done),
    .fail      (fail),
    .take_rsp  (take_rsp),
    .busy_flag (busy_flag)
  );

  logic [RSP_WORDS-1:0][WORD_W-1:0] rsp_words;
  sdh_resp_pack #(.NW(RSP_WORDS)) u_pack (
    .raw      (card_rsp_data),
    .long_fmt (card_rsp_len == LEN_W'(16)),
    .words    (rsp_words)
  );

  logic [STAT_W-1:0] st_set, st_clr;
  always_comb begin
    st_set = '0;
    st_set[SB_CMDTO]   = fail;
    st_set[SB_BUSYIRQ] = busy_flag;
    st_clr = (bus_wr && hit_stat) ? bus_wdata[STAT_W-1:0] : '0;
  end

  sdh_status #(.SW(STAT_W), .IRQ_MASK(IRQ_SRC_MASK)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_bits (st_set),
    .clr_bits (st_clr),
    .status   (stat_q),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      arg_q   <= '0;
      rsp_q   <= '0;
      cfg_q   <= '0;
      bsize_q <= '0;
      bcnt_q  <= '0;
    end else begin
      if (bus_wr && hit_cmd && !pending) begin
        cmd_q <= bus_wdata[CMD_W-1:0];
      end else if (done) begin
        cmd_q[CB_START] <= 1'b0;
        if (fail) cmd_q[CB_FAIL] <= 1'b1;
      end
      if (take_rsp) rsp_q <= rsp_words;
      if (bus_wr && hit_arg)   arg_q   <= bus_wdata;
      if (bus_wr && hit_cfg)   cfg_q   <= bus_wdata[CFG_W-1:0];
      if (bus_wr && hit_bsize) bsize_q <= bus_wdata;
      if (bus_wr && hit_bcnt)  bcnt_q  <= bus_wdata[BCNT_W-1:0];
    end
  end

  logic [WORD_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_cmd)   rd_mux = WORD_W'(cmd_q);
    if (hit_arg)   rd_mux = arg_q;
    if (hit_stat)  rd_mux = WORD_W'(stat_q);
    if (hit_cfg)   rd_mux = WORD_W'(cfg_q);
    if (hit_bsize) rd_mux = bsize_q;
    if (hit_bcnt)  rd_mux = WORD_W'(bcnt_q);
    for (int k = 0; k < RSP_WORDS; k++) begin
      if (bus_addr == ADDR_W'(OFF_RSP0 + 8'(4 * k))) rd_mux = rsp_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/sdh_cmd_regs_chk.sv
module sdh_cmd_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        rsp_valid,
  input logic        pending,
  input logic        cmd_start,
  input logic        cmd_fail,
  input logic [10:0] stat,
  input logic        busy_en,
  input logic        stat_wr,
  input logic        clr_to,
  input logic        set_to,
  input logic        irq
);
  // R2: the request is a single-cycle pulse
  p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
  // R2: a request only travels with a pending command
  p_req_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> pending);
  // R3: response clears the start bit
  p_start_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && pending) |=> !cmd_start);
  // R6: a new failure comes with the timeout flag
  p_fail_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_fail) |-> stat[6]);
  // R7: busy flag needs the enable
  p_busy_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[10]) |-> $past(busy_en));
  // R8: write-one clears the timeout flag
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && clr_to && !set_to) |=> !stat[6]);
  // R9: interrupt follows its sources one cycle later
  p_irq_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat[10:8]) |=> irq);
  p_irq_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|stat[10:8]) |=> !irq);
endmodule

bind sdh_cmd_regs sdh_cmd_regs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (card_req_valid),
  .rsp_valid (card_rsp_valid),
  .pending   (pending),
  .cmd_start (cmd_q[15]),
  .cmd_fail  (cmd_q[14]),
  .stat      (stat_q),
  .busy_en   (cfg_q[10]),
  .stat_wr   (bus_wr && hit_stat),
  .clr_to    (bus_wdata[6]),
  .set_to    (fail),
  .irq       (irq)
);

// File: tb/sdh_cmd_regs_test.sv
module sdh_cmd_regs_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic card_req_valid;
  logic [5:0] card_req_index;
  logic [31:0] card_req_arg;
  logic card_rsp_valid = 1'b0;
  logic [4:0] card_rsp_len = '0;
  logic [127:0] card_rsp_data = '0;
  logic irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdh_cmd_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .card_req_valid(card_req_valid), .card_req_index(card_req_index),
    .card_req_arg(card_req_arg), .card_rsp_valid(card_rsp_valid),
    .card_rsp_len(card_rsp_len), .card_rsp_data(card_rsp_data), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  task automatic respond(input logic [4:0] len, input logic [127:0] data, input int lat);
    repeat (lat) @(negedge clk);
    card_rsp_valid = 1'b1; card_rsp_len = len; card_rsp_data = data;
    @(negedge clk); card_rsp_valid = 1'b0;
  endtask

  function automatic logic [127:0] bytes_from(input logic [7:0] base);
    logic [127:0] v;
    for (int k = 0; k < 16; k++) v[8*k +: 8] = base + 8'(k);
    return v;
  endfunction

  task automatic t_reset;
    check("R1 irq", 32'(irq), 0);
    check("R1 req", 32'(card_req_valid), 0);
    rd_chk("R1 cmd", 8'h00, 0);
    rd_chk("R1 arg", 8'h04, 0);
    rd_chk("R1 rsp0", 8'h10, 0);
    rd_chk("R1 stat", 8'h20, 0);
    rd_chk("R1 cfg", 8'h38, 0);
    rd_chk("R1 bcnt", 8'h50, 0);
  endtask

  task automatic t_storage;
    wr(8'h3C, 32'h0000_0200);
    rd_chk("R12 bsize", 8'h3C, 32'h200);
    wr(8'h50, 32'hFFFF_FFFF);
    rd_chk("R12 bcnt", 8'h50, 32'h1FF);
    wr(8'h38, 32'hFFFF_FBFF);
    rd_chk("R12 cfg", 8'h38, 32'h3FF);
    wr(8'h38, 32'h0);
    wr(8'h10, 32'h1234_5678);
    rd_chk("R12 rsp ro", 8'h10, 0);
    rd_chk("R11 hold", 8'h04, 0);
    @(negedge clk);
    check("R11 held", bus_rdata, 0);
  endtask

  task automatic t_short;
    wr(8'h04, 32'hCAFE_BABE);
    rd_chk("R12 arg", 8'h04, 32'hCAFE_BABE);
    wr(8'h00, 32'h8011);
    check("R2 req", 32'(card_req_valid), 1);
    check("R2 idx", 32'(card_req_index), 32'h11);
    check("R2 arg", card_req_arg, 32'hCAFE_BABE);
    @(negedge clk);
    check("R2 pulse", 32'(card_req_valid), 0);
    rd_chk("R2 pending", 8'h00, 32'h8011);
    respond(5'd4, bytes_from(8'h10), 2);
    rd_chk("R3 done", 8'h00, 32'h0011);
    rd_chk("R4 w0", 8'h10, 32'h1011_1213);
    rd_chk("R4 w1", 8'h14, 0);
    rd_chk("R4 w3", 8'h1C, 0);
    rd_chk("R6 no fail", 8'h20, 0);
  endtask

  task automatic t_long;
    wr(8'h00, 32'h8202);
    respond(5'd16, bytes_from(8'hA0), 3);
    rd_chk("R5 cmd", 8'h00, 32'h0202);
    rd_chk("R5 w0", 8'h10, 32'hACAD_AEAF);
    rd_chk("R5 w1", 8'h14, 32'hA8A9_AAAB);
    rd_chk("R5 w2", 8'h18, 32'hA4A5_A6A7);
    rd_chk("R5 w3", 8'h1C, 32'hA0A1_A2A3);
  endtask

  task automatic t_fail;
    wr(8'h00, 32'h8202);
    respond(5'd4, bytes_from(8'h50), 1);
    rd_chk("R6 cmd fail", 8'h00, 32'h4202);
    rd_chk("R6 stat", 8'h20, 32'h40);
    rd_chk("R6 rsp kept", 8'h10, 32'hACAD_AEAF);
    wr(8'h20, 32'h40);
    rd_chk("R8 clr", 8'h20, 0);
    wr(8'h00, 32'h8003);
    respond(5'd0, '0, 1);
    rd_chk("R6 len0", 8'h00, 32'h4003);
    wr(8'h20, 32'h7FF);
    wr(8'h00, 32'h8003);
    respond(5'd8, bytes_from(8'h00), 0);
    rd_chk("R6 len8", 8'h20, 32'h40);
    rd_chk("R6 len8 rsp", 8'h1C, 32'hA0A1_A2A3);
    wr(8'h20, 32'h40);
  endtask

  task automatic t_norsp;
    wr(8'h00, 32'h8400);
    respond(5'd0, bytes_from(8'h77), 2);
    rd_chk("R3 norsp cmd", 8'h00, 32'h0400);
    rd_chk("R3 norsp stat", 8'h20, 0);
    rd_chk("R3 norsp rsp", 8'h10, 32'hACAD_AEAF);
  endtask

  task automatic t_busy;
    wr(8'h00, 32'h8C00);
    respond(5'd0, '0, 1);
    rd_chk("R7 gated", 8'h20, 0);
    check("R9 no irq", 32'(irq), 0);
    wr(8'h38, 32'h400);
    wr(8'h00, 32'h8C00);
    respond(5'd0, '0, 1);
    check("R9 irq lag", 32'(irq), 0);
    @(negedge clk);
    check("R9 irq rise", 32'(irq), 1);
    rd_chk("R7 busy", 8'h20, 32'h400);
    wr(8'h20, 32'h040);
    rd_chk("R8 keep", 8'h20, 32'h400);
    check("R9 irq held", 32'(irq), 1);
    wr(8'h20, 32'h400);
    check("R9 fall lag", 32'(irq), 1);
    @(negedge clk);
    check("R9 irq fall", 32'(irq), 0);
    rd_chk("R8 cleared", 8'h20, 0);
  endtask

  task automatic t_unmapped;
    wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    rd_chk("R10 rd44", 8'h44, 0);
    rd_chk("R10 rd40", 8'h40, 0);
    rd_chk("R10 arg intact", 8'h04, 32'hCAFE_BABE);
    rd_chk("R10 cfg intact", 8'h38, 32'h400);
    wr(8'h00, 32'h8009);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h8005;
    @(negedge clk); bus_wr = 1'b0;
    check("R10 no 2nd req", 32'(card_req_valid), 0);
    respond(5'd4, bytes_from(8'h00), 0);
    rd_chk("R10 first kept", 8'h00, 32'h0009);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_storage();
    t_short();
    t_long();
    t_fail();
    t_norsp();
    t_busy();
    t_unmapped();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule